// File: doc/BRIEF.md
# Codec startup and mute sequencer

This block sequences the digital core of an audio converter from power-down to normal operation. The chip reset input holds it in power-down. In the first master-clock cycle after reset is released it samples a strap level, which is the level present on the serial data output pin, to choose the configuration mode. A high strap selects hardware mode, and power-up starts at once. A low strap selects software mode, and power-up waits until software clears its power-down bit.

Power-up first waits out a programmable reference settling delay, counted in master-clock cycles. The block then measures the master-clock to frame-clock ratio by counting master clocks between consecutive frame-clock rising edges. Once a supported ratio is confirmed, the block enters normal operation.

In normal operation the block keeps checking the ratio on every frame. It treats a lasting change of ratio as a clock change. During a clock change it forces zero DAC data and drops back into detection. The mute-control outputs are active low and per channel. They stay asserted in every state except normal operation, and also while that channel's mute request is set.

Top module: `codec_boot_seq`

## Requirements
- R1: While rst_ni is low, the block is in power-down. In that state ref_en_o=0, ref_ready_o=0, run_o=0, zero_data_o=1, sdout_mute_o=1 and every mute_n_o bit is 0. Pulling rst_ni low takes effect at once, without waiting for a clock edge.
- R2: strap_i is sampled at the first clock edge after rst_ni rises. A value of 1 selects hardware mode (mode_hw_o=1), and ref_en_o rises at that same edge whatever pdn_i is. Later changes on strap_i do not alter mode_hw_o.
- R3: A strap value of 0 selects software mode (mode_hw_o=0). ref_en_o stays 0 while pdn_i=1. The ramp starts at the first edge that sees pdn_i=0.
- R4: ref_en_o is high for exactly max(ramp_len_i,1) clock cycles before ref_ready_o rises. The outputs stay muted during that time.
- R5: A measurement is the number of clk_i cycles between two consecutive lrck_i rising edges. The supported ratios are coded as follows: ratio_o code k stands for 128·2^(k/2) when k is even and 192·2^(k/2) when k is odd, so 0=128, 1=192, 2=256, 3=384 and 4=512. run_o rises only after two consecutive equal supported measurements. ratio_o then shows the code.
- R6: A measurement that matches no supported ratio keeps run_o=0 and the outputs muted, and detection retries on the following frames.
- R7: While run_o=1, a single frame whose measurement differs from the stored ratio is ignored. Two consecutive differing frames are a clock change: run_o drops and zero_data_o rises. Detection then restarts, and a new ratio can be locked.
- R8: mute_n_o[k] is low except when run_o was 1 and mute_req_i[k] was 0 at the previous clock edge. The output is registered, so it lags by one cycle.
- R9: In software mode, pdn_i=1 in any powered state returns the block to the hold state within one cycle, with ref_en_o=0 and run_o=0. In hardware mode pdn_i has no effect.
- R10: zero_data_o and sdout_mute_o are 1 whenever run_o is 0, and 0 whenever run_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous chip reset |
| strap_i | input | 1 | Mode strap, the level seen on the serial data output pin |
| pdn_i | input | 1 | Software power-down bit (used in software mode only) |
| lrck_i | input | 1 | Frame clock, synchronous to clk_i |
| ramp_len_i | input | RAMP_W | Reference settling delay in clk_i cycles |
| mute_req_i | input | NCH | Per-channel mute request (software or hardware mute) |
| mode_hw_o | output | 1 | 1 = hardware mode, 0 = software mode |
| ref_en_o | output | 1 | Reference and converter enable |
| ref_ready_o | output | 1 | Settling delay finished |
| run_o | output | 1 | Normal operation |
| ratio_o | output | CODE_W | Locked ratio code |
| zero_data_o | output | 1 | Force zero DAC data |
| sdout_mute_o | output | 1 | Mute the serial data output |
| mute_n_o | output | NCH | Active-low external mute controls |

## Verification
The bench checks the exact length of the settling window with a zero and a nonzero delay. A design with an off-by-one counter would report 0, 2 or 21 ramp cycles instead of 1 or 20. It sends a single odd-length frame during normal operation; a design that unlocks on one bad frame makes the scoreboard see an extra, unexpected lock. It then applies an unsupported ratio, and a design that locks on any count would raise run_o when no lock is expected. It also changes the strap after release and toggles the power-down bit in both modes; a design that samples the strap continuously or obeys pdn_i in hardware mode would drop out of normal operation.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [2:0] {
    ST_PDN    = 3'd0,
    ST_HOLD   = 3'd1,
    ST_RAMP   = 3'd2,
    ST_DETECT = 3'd3,
    ST_RUN    = 3'd4
  } state_e;

  // code k: even -> 128<<(k/2), odd -> 192<<(k/2)
  function automatic int ratio_of(input int k);
    int base;
    base = (k % 2 == 0) ? 128 : 192;
    return base << (k / 2);
  endfunction
endpackage

// File: rtl/cbs_ramp_timer.sv
module cbs_ramp_timer #(
  parameter int RAMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RAMP_W-1:0] len_i,
  output logic              done_o
);
  logic [RAMP_W-1:0] cnt_q;

  // zero length behaves as one cycle
  assign done_o = en_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (!done_o)        cnt_q <= cnt_q + 1'b1;
  end

  // R4
  ramp_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> cnt_q == '0);
endmodule

// File: rtl/cbs_ratio_meas.sv
module cbs_ratio_meas
  import cbs_pkg::*;
#(
  parameter int NUM_RATIOS = 5,
  parameter int CNT_W      = 11,
  parameter int CODE_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              lrck_i,
  output logic              stb_o,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic             lrck_q, have_edge_q, rise;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_RATIOS-1:0] hit_vec;

  assign rise = lrck_i && !lrck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_q      <= 1'b0;
      have_edge_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      lrck_q <= lrck_i;
      if (!en_i) begin
        have_edge_q <= 1'b0;
        cnt_q       <= '0;
      end else if (rise) begin
        have_edge_q <= 1'b1;
        cnt_q       <= CNT_W'(1);
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_tab
    assign hit_vec[k] = (cnt_q == CNT_W'(ratio_of(k)));
  end

  always_comb begin
    code_o = '0;
    for (int k = 0; k < NUM_RATIOS; k++)
      if (hit_vec[k]) code_o = CODE_W'(k);
  end

  assign stb_o = en_i && rise && have_edge_q;
  assign hit_o = |hit_vec;

  // R5
  ratio_table_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/cbs_mute_drv.sv
module cbs_mute_drv #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [NCH-1:0] req_i,
  output logic [NCH-1:0] mute_n_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mute_n_o[c] <= 1'b0;
      else         mute_n_o[c] <= run_i && !req_i[c];
    end
  end

  // R8
  mute_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> mute_n_o == '0);
endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
  import cbs_pkg::*;
#(
  parameter int  NCH        = 2,
  parameter int  RAMP_W     = 16,
  parameter int  NUM_RATIOS = 5,
  localparam int CODE_W     = (NUM_RATIOS > 1) ? $clog2(NUM_RATIOS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic              pdn_i,
  input  logic              lrck_i,
  input  logic [RAMP_W-1:0] ramp_len_i,
  input  logic [NCH-1:0]    mute_req_i,
  output logic              mode_hw_o,
  output logic              ref_en_o,
  output logic              ref_ready_o,
  output logic              run_o,
  output logic [CODE_W-1:0] ratio_o,
  output logic              zero_data_o,
  output logic              sdout_mute_o,
  output logic [NCH-1:0]    mute_n_o
);
  localparam int CNT_W = $clog2(ratio_of(NUM_RATIOS - 1)) + 2;

  state_e            state_q;
  logic              mode_q, cand_vld_q, miss_q, sw_pdn;
  logic [CODE_W-1:0] cand_q, ratio_q;
  logic              ramp_done, meas_en, meas_stb, meas_hit;
  logic [CODE_W-1:0] meas_code;

  assign sw_pdn  = !mode_q && pdn_i;
  assign meas_en = (state_q == ST_DETECT) || (state_q == ST_RUN);

  cbs_ramp_timer #(.RAMP_W(RAMP_W)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_RAMP),
    .len_i  (ramp_len_i),
    .done_o (ramp_done)
  );

  cbs_ratio_meas #(.NUM_RATIOS(NUM_RATIOS), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_meas (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (meas_en),
    .lrck_i (lrck_i),
    .stb_o  (meas_stb),
    .hit_o  (meas_hit),
    .code_o (meas_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PDN;
      mode_q     <= 1'b0;
      cand_vld_q <= 1'b0;
      cand_q     <= '0;
      ratio_q    <= '0;
      miss_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PDN: begin
          mode_q  <= strap_i;  // strap sampled once, at release
          state_q <= (strap_i || !pdn_i) ? ST_RAMP : ST_HOLD;
        end
        ST_HOLD: begin
          cand_vld_q <= 1'b0;
          miss_q     <= 1'b0;
          if (!pdn_i) state_q <= ST_RAMP;
        end
        ST_RAMP: begin
          if (sw_pdn)         state_q <= ST_HOLD;
          else if (ramp_done) state_q <= ST_DETECT;
        end
        ST_DETECT: begin
          if (sw_pdn) begin
            state_q <= ST_HOLD;
          end else if (meas_stb) begin
            if (!meas_hit) begin
              cand_vld_q <= 1'b0;
            end else if (cand_vld_q && cand_q == meas_code) begin
              ratio_q    <= meas_code;
              miss_q     <= 1'b0;
              state_q    <= ST_RUN;
            end else begin
              cand_q     <= meas_code;
              cand_vld_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (sw_pdn) begin
            state_q <= ST_HOLD;
          end else if (meas_stb) begin
            if (meas_hit && meas_code == ratio_q) begin
              miss_q <= 1'b0;
            end else if (miss_q) begin
              // second deviating frame: clock change
              miss_q     <= 1'b0;
              cand_vld_q <= 1'b0;
              state_q    <= ST_DETECT;
            end else begin
              miss_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_PDN;
      endcase
    end
  end

  cbs_mute_drv #(.NCH(NCH)) u_mute (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_o),
    .req_i    (mute_req_i),
    .mute_n_o (mute_n_o)
  );

  assign mode_hw_o    = mode_q;
  assign ref_en_o     = meas_en || (state_q == ST_RAMP);
  assign ref_ready_o  = meas_en;
  assign run_o        = (state_q == ST_RUN);
  assign ratio_o      = ratio_q;
  assign zero_data_o  = !run_o;
  assign sdout_mute_o = !run_o;

  // R5
  ratio_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> ratio_q < CODE_W'(NUM_RATIOS));
  // R5
  run_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(state_q) == ST_DETECT);
  // R4
  ramp_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DETECT && $past(state_q) == ST_RAMP) |-> $past(ramp_done));
  // R9
  hold_sw_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOLD |-> !mode_q);
endmodule

// File: tb/codec_boot_seq_test.sv
module codec_boot_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int RAMP_W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0, strap_i = 1'b0, pdn_i = 1'b1, lrck_i = 1'b0;
  logic [RAMP_W-1:0] ramp_len_i = '0;
  logic [NCH-1:0] mute_req_i = '0;
  logic mode_hw_o, ref_en_o, ref_ready_o, run_o, zero_data_o, sdout_mute_o;
  logic [2:0] ratio_o;
  logic [NCH-1:0] mute_n_o;

  codec_boot_seq #(.NCH(NCH), .RAMP_W(RAMP_W)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int tests = 0, fails = 0, falls = 0;
  int lr_per = 256, glitch = 0;
  int exp_q[$];
  logic run_prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // frame clock generator, driven on negedges
  initial forever begin
    int p;
    p = (glitch != 0) ? glitch : lr_per;
    glitch = 0;
    lrck_i = 1'b1;
    repeat (p/2) @(negedge clk_i);
    lrck_i = 1'b0;
    repeat (p - p/2) @(negedge clk_i);
  end

  // scoreboard monitor: each lock pops one expected ratio code
  initial forever begin
    @(negedge clk_i);
    if (run_o && !run_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected lock", ratio_o, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(ratio_o == 3'(e), "R5 locked ratio code", ratio_o, e);
      end
    end
    if (!run_o && run_prev) falls++;
    run_prev = run_o;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic wait_run(input bit lvl, input string req);
    int t = 0;
    while (run_o != lvl && t < 8000) begin @(negedge clk_i); t++; end
    check(run_o == lvl, req, run_o, lvl);
  endtask

  task automatic count_ramp(input int exp, input string req);
    int n = 0, t = 0;
    while (!ref_ready_o && t < 1000) begin
      if (ref_en_o) n++;
      if (ref_en_o && mute_n_o != '0) check(1'b0, "R4 muted during ramp", mute_n_o, 0);
      @(negedge clk_i); t++;
    end
    check(n == exp, req, n, exp);
  endtask

  initial begin
    int f0;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(!ref_en_o && !ref_ready_o && !run_o, "R1 powered down in reset", ref_en_o, 0);
    check(zero_data_o && sdout_mute_o && mute_n_o == '0, "R1 muted in reset", mute_n_o, 0);

    // hardware boot, pdn_i held high
    strap_i = 1'b1; pdn_i = 1'b1; ramp_len_i = 16'd20;
    exp_q.push_back(2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(mode_hw_o == 1'b1, "R2 hw mode selected", mode_hw_o, 1);
    check(ref_en_o == 1'b1, "R2 ramp starts at release", ref_en_o, 1);
    strap_i = 1'b0;
    count_ramp(20, "R4 ramp length 20");
    check(run_o == 1'b0 && zero_data_o, "R10 zero data before lock", run_o, 0);
    wait_run(1'b1, "R5 lock at 256");
    check(mode_hw_o == 1'b1, "R2 strap change ignored", mode_hw_o, 1);
    check(!zero_data_o && !sdout_mute_o, "R10 data released in run", zero_data_o, 0);
    @(negedge clk_i);
    check(mute_n_o == 2'b11, "R8 unmuted in run", mute_n_o, 3);

    // R8 per-channel mute
    mute_req_i = 2'b01;
    @(negedge clk_i);
    check(mute_n_o == 2'b10, "R8 channel 0 muted", mute_n_o, 2);
    mute_req_i = 2'b00;
    @(negedge clk_i);
    check(mute_n_o == 2'b11, "R8 channel 0 released", mute_n_o, 3);

    // R9 pdn ignored in hw mode
    f0 = falls;
    pdn_i = 1'b1;
    repeat (20) @(negedge clk_i);
    check(run_o && falls == f0, "R9 pdn ignored in hw mode", run_o, 1);
    pdn_i = 1'b0;

    // R7 single odd frame tolerated
    glitch = 300;
    repeat (900) @(negedge clk_i);
    check(run_o && falls == f0, "R7 single deviating frame ignored", falls - f0, 0);

    // R7 real clock change
    lr_per = 512;
    exp_q.push_back(4);
    wait_run(1'b0, "R7 unlock on clock change");
    check(zero_data_o == 1'b1, "R7 zero data during change", zero_data_o, 1);
    @(negedge clk_i);
    check(mute_n_o == '0, "R7 muted during change", mute_n_o, 0);
    wait_run(1'b1, "R7 relock at 512");

    // R6 unsupported ratio
    lr_per = 300;
    wait_run(1'b0, "R6 unlock on 300");
    repeat (3000) @(negedge clk_i);
    check(run_o == 1'b0 && mute_n_o == '0, "R6 no lock on 300", run_o, 0);
    lr_per = 384;
    exp_q.push_back(3);
    wait_run(1'b1, "R6 retry locks 384");

    // R1 asynchronous reset during run
    #2 rst_ni = 1'b0;
    #1;
    check(!ref_en_o && !run_o && zero_data_o && mute_n_o == '0, "R1 async reset", run_o, 0);

    // software boot
    strap_i = 1'b0; pdn_i = 1'b1; ramp_len_i = 16'd0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    check(mode_hw_o == 1'b0 && ref_en_o == 1'b0, "R3 sw mode holds", ref_en_o, 0);
    pdn_i = 1'b0;
    exp_q.push_back(3);
    @(negedge clk_i);
    check(ref_en_o == 1'b1, "R3 ramp after pdn clear", ref_en_o, 1);
    count_ramp(1, "R4 zero length ramp");
    wait_run(1'b1, "R5 sw lock at 384");

    // R9 pdn in sw mode
    pdn_i = 1'b1;
    @(negedge clk_i);
    check(!run_o && !ref_en_o, "R9 pdn returns to hold", ref_en_o, 0);
    @(negedge clk_i);
    check(mute_n_o == '0, "R9 muted in hold", mute_n_o, 0);

    check(exp_q.size() == 0, "R5 all expected locks seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule